// File: doc/BRIEF.md
# Long-Frame Asynchronous Serial Receiver

This block receives asynchronous serial characters that are much longer than usual. Each character is one start bit, a 32-bit data word, an even parity bit and two stop bits, so a single character lasts 36 bit times. The block samples the line at 16 times the bit rate. Its bit-phase counter is re-centred on every line transition inside the frame, and not only on the start edge. The receiver therefore follows a sender whose bit rate differs noticeably from its own, provided the data has reasonably frequent transitions. The default rate is 9600 bit/s, derived from the system clock through parameters.

Each completed word goes into an eight-entry first-in first-out buffer with a show-ahead read port. The head word is always visible on `rd_data`, and a read strobe removes it. Three sticky flags report line problems:

- **Parity error.** A parity mismatch sets this flag. The word is still stored.
- **Framing error.** A low stop bit sets this flag, and the word is thrown away.
- **Overrun.** A good word that arrives while the buffer is full is lost, and this flag is set.

Top module: `longframe_rx`

## Requirements
- R1: After reset, `fifo_empty` is 1, `fifo_full` is 0 and `parity_err`, `frame_err` and `overrun_err` are all 0.
- R2: A frame is a low start bit, 32 data bits sent least significant bit first, one parity bit and two high stop bits, with a nominal bit time of 16 sample ticks. A correctly framed word appears at `rd_data` with `fifo_empty` low before the end of the second stop bit.
- R3: A low pulse on an idle line that ends before the middle of a bit time is rejected as a false start. It stores no word and changes no flag.
- R4: Every line transition after the start bit moves the next sample point to half a bit time after that transition. Frames whose bit time is 6.25 % longer or shorter than nominal are received correctly when no run of equal bits is longer than four.
- R5: Parity is even: data bits plus the parity bit hold an even number of ones. A mismatch in a frame with good stop bits sets `parity_err`, and the word is still stored.
- R6: `parity_err` is cleared by a read that removes a word (`rd_en` high while `fifo_empty` is low) or by `err_clear`.
- R7: If either stop bit is sampled low, `frame_err` is set. The word is discarded and `parity_err` is not updated for that frame.
- R8: The buffer holds 8 words and returns them in arrival order. `fifo_full` is high exactly when 8 words are held. `rd_en` while `fifo_empty` is high changes nothing.
- R9: A word with good stop bits that completes while the buffer is full is dropped, `overrun_err` is set and the buffered words are unchanged.
- R10: A one-cycle `err_clear` pulse clears `parity_err`, `frame_err` and `overrun_err`, and leaves the buffer untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial input line, idle high |
| rd_en | input | 1 | Remove the head word from the buffer |
| err_clear | input | 1 | Clear all sticky error flags |
| rd_data | output | 32 | Head word of the buffer (show-ahead) |
| fifo_empty | output | 1 | Buffer holds no word |
| fifo_full | output | 1 | Buffer holds 8 words |
| parity_err | output | 1 | Sticky parity mismatch flag |
| frame_err | output | 1 | Sticky low-stop-bit flag |
| overrun_err | output | 1 | Sticky word-lost flag |

## Verification
The final stop bit is sampled about half a bit time after it starts. That sample is taken three synchronizer cycles, up to one tick period and one register stage later than the line change. All of a frame's effects on the buffer and the flags are therefore due well inside the second stop bit. The bench keeps the line high for two further bit times after each frame before it compares `rd_data`, the buffer flags and the error flags with its own model. A read or clear strobe acts at the next rising edge, so the bench drives it for one cycle and compares at the following falling edge. Directed frames cover each bit position, false starts, slow and fast senders and both stop-bit faults. A seeded random run mixes words, bit times, parity and stop faults, reads and clears.

// File: rtl/longframe_rx_pkg.sv
package longframe_rx_pkg;

   // Receive sequencer phases; order is the frame order on the line.
   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PARITY,
      RX_STOP
   } rx_phase_e;

   // Width needed to hold values 0 .. n-1, never less than one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lfr_sync.sv
module lfr_sync #(
   parameter int STAGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("lfr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   // Reset to the idle (high) line level so no false start follows reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lfr_tick.sv
module lfr_tick #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("lfr_tick: DIV must be at least 1");
      end
      if (DIV <= 1) begin : g_every_cycle
         wire unused_tick_inputs = clk ^ rst_n;
         assign tick = 1'b1;
      end else begin : g_divided
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + 1'b1;
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/lfr_frame.sv
module lfr_frame
   import longframe_rx_pkg::*;
#(
   parameter int DW         = 32,
   parameter int SB         = 2,
   parameter int OS         = 16,
   parameter bit PARITY_ODD = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          rx_bit,
   output logic [DW-1:0] word_o,
   output logic          done_o,
   output logic          par_bad_o,
   output logic          stop_bad_o
);
   localparam int PW   = idx_width(OS);
   localparam int IW   = idx_width(DW);
   localparam int HALF = OS / 2;
   localparam logic [PW-1:0] PH_HALF = PW'(HALF - 1);
   localparam logic [PW-1:0] PH_FULL = PW'(OS - 1);
   localparam logic [IW-1:0] LAST_DATA = IW'(DW - 1);
   localparam logic [IW-1:0] LAST_STOP = IW'(SB - 1);

   generate
      if (OS < 4 || (OS % 2) != 0) begin : g_bad_os
         $error("lfr_frame: OS must be even and at least 4");
      end
      if (DW < 2 || SB < 1 || SB > DW) begin : g_bad_frame
         $error("lfr_frame: need DW >= 2 and 1 <= SB <= DW");
      end
   endgenerate

   rx_phase_e      state;
   logic [PW-1:0]  ph;
   logic [IW-1:0]  idx;
   logic [DW-1:0]  shreg;
   logic           par_acc;
   logic           par_bad_r;
   logic           stop_bad_r;
   logic           rx_prev;

   logic fall_edge, any_edge, smp, stop_bad_next;
   assign fall_edge     = rx_prev & ~rx_bit;
   assign any_edge      = rx_prev ^ rx_bit;
   assign smp           = tick && (ph == '0);
   assign stop_bad_next = stop_bad_r | ~rx_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= RX_IDLE;
         ph         <= '0;
         idx        <= '0;
         shreg      <= '0;
         par_acc    <= 1'b0;
         par_bad_r  <= 1'b0;
         stop_bad_r <= 1'b0;
         rx_prev    <= 1'b1;
         done_o     <= 1'b0;
         par_bad_o  <= 1'b0;
         stop_bad_o <= 1'b0;
      end else begin
         rx_prev    <= rx_bit;
         done_o     <= 1'b0;
         par_bad_o  <= 1'b0;
         stop_bad_o <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (fall_edge) begin
                  state <= RX_START;
                  ph    <= PH_HALF;
               end
            end
            RX_START: begin
               if (smp) begin
                  if (!rx_bit) begin
                     state   <= RX_DATA;
                     ph      <= PH_FULL;
                     idx     <= '0;
                     par_acc <= PARITY_ODD;
                  end else begin
                     state <= RX_IDLE;
                  end
               end else if (tick) begin
                  ph <= ph - 1'b1;
               end
            end
            default: begin
               if (smp) begin
                  ph <= PH_FULL;
                  case (state)
                     RX_DATA: begin
                        shreg   <= {rx_bit, shreg[DW-1:1]};
                        par_acc <= par_acc ^ rx_bit;
                        if (idx == LAST_DATA) state <= RX_PARITY;
                        else                  idx   <= idx + 1'b1;
                     end
                     RX_PARITY: begin
                        par_bad_r  <= par_acc ^ rx_bit;
                        stop_bad_r <= 1'b0;
                        idx        <= '0;
                        state      <= RX_STOP;
                     end
                     default: begin
                        if (idx == LAST_STOP) begin
                           state <= RX_IDLE;
                           if (stop_bad_next) begin
                              stop_bad_o <= 1'b1;
                           end else begin
                              done_o    <= 1'b1;
                              par_bad_o <= par_bad_r;
                           end
                        end else begin
                           idx        <= idx + 1'b1;
                           stop_bad_r <= stop_bad_next;
                        end
                     end
                  endcase
               end else if (any_edge) begin
                  ph <= PH_HALF;
               end else if (tick) begin
                  ph <= ph - 1'b1;
               end
            end
         endcase
      end
   end

   assign word_o = shreg;

   // Checker state: ticks since the last sample or resync point.
   logic [PW:0] tk_cnt;
   logic        in_frame;
   assign in_frame = (state == RX_DATA) || (state == RX_PARITY) || (state == RX_STOP);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       tk_cnt <= '0;
      else if (!in_frame || smp || any_edge) tk_cnt <= '0;
      else if (tick)                    tk_cnt <= tk_cnt + 1'b1;
   end

   // R4: a sample is never more than one bit time after the last anchor.
   assert_sample_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && tick) |-> (tk_cnt < (PW+1)'(OS)));

   // R7: a completed frame is either delivered or rejected, never both.
   assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && stop_bad_o));
endmodule

// File: rtl/lfr_fifo.sv
module lfr_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("lfr_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
      end
   end

   assign rdata = mem[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/longframe_rx.sv
module longframe_rx #(
   parameter int CLK_HZ      = 50_000_000,
   parameter int BAUD        = 9600,
   parameter int DATA_BITS   = 32,
   parameter int STOP_BITS   = 2,
   parameter int OVERSAMPLE  = 16,
   parameter int FIFO_DEPTH  = 8,
   parameter int SYNC_STAGES = 3,
   parameter bit PARITY_ODD  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rx_line,
   input  logic                 rd_en,
   input  logic                 err_clear,
   output logic [DATA_BITS-1:0] rd_data,
   output logic                 fifo_empty,
   output logic                 fifo_full,
   output logic                 parity_err,
   output logic                 frame_err,
   output logic                 overrun_err
);
   localparam int TICK_DIV = CLK_HZ / (BAUD * OVERSAMPLE);

   generate
      if (TICK_DIV < 1) begin : g_bad_rate
         $error("longframe_rx: clock too slow for BAUD * OVERSAMPLE");
      end
   endgenerate

   logic                 rx_bit, tick;
   logic [DATA_BITS-1:0] word;
   logic                 f_done, f_par_bad, f_stop_bad;
   logic                 push, pop;

   lfr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rx_bit));

   lfr_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   lfr_frame #(
      .DW(DATA_BITS), .SB(STOP_BITS), .OS(OVERSAMPLE), .PARITY_ODD(PARITY_ODD)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_bit(rx_bit),
      .word_o(word), .done_o(f_done), .par_bad_o(f_par_bad), .stop_bad_o(f_stop_bad));

   assign push = f_done & ~fifo_full;
   assign pop  = rd_en & ~fifo_empty;

   lfr_fifo #(.DW(DATA_BITS), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(word), .pop(pop),
      .rdata(rd_data), .empty(fifo_empty), .full(fifo_full));

   // Sticky flags: a new event wins over a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         parity_err  <= 1'b0;
         frame_err   <= 1'b0;
         overrun_err <= 1'b0;
      end else begin
         if (f_done && f_par_bad)    parity_err <= 1'b1;
         else if (err_clear || pop)  parity_err <= 1'b0;

         if (f_stop_bad)             frame_err <= 1'b1;
         else if (err_clear)         frame_err <= 1'b0;

         if (f_done && fifo_full)    overrun_err <= 1'b1;
         else if (err_clear)         overrun_err <= 1'b0;
      end
   end

   assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_err) |-> $past(fifo_full));
   assert_frame_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      f_stop_bad |-> !push);
   assert_clear_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clear && !f_done && !f_stop_bad) |=> (!frame_err && !overrun_err && !parity_err));
endmodule

// File: tb/longframe_rx_bench.sv
module longframe_rx_bench;
   localparam int DW    = 32;
   localparam int DEPTH = 8;
   localparam int NOM   = 32;   // cycles per bit: 16 ticks x 2 cycles

   logic clk = 1'b0;
   always #4 clk = ~clk;       // 125 MHz

   logic          rst_n = 1'b0, rx_line = 1'b1, rd_en = 1'b0, err_clear = 1'b0;
   logic [DW-1:0] rd_data;
   logic          fifo_empty, fifo_full, parity_err, frame_err, overrun_err;

   longframe_rx #(.CLK_HZ(125_000_000), .BAUD(3_906_250)) u_longframe_rx (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rd_en(rd_en), .err_clear(err_clear),
      .rd_data(rd_data), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .parity_err(parity_err), .frame_err(frame_err), .overrun_err(overrun_err));

   int checks = 0, errors = 0;
   bit finished = 1'b0;
   logic [DW-1:0] exp_q[$];
   logic m_par = 1'b0, m_frm = 1'b0, m_ovr = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic check_state(input string req);
      logic e_empty, e_full;
      e_empty = (exp_q.size() == 0);
      e_full  = (exp_q.size() == DEPTH);
      check(fifo_empty == e_empty, req, "fifo_empty", 32'(fifo_empty), 32'(e_empty));
      check(fifo_full == e_full,   req, "fifo_full",  32'(fifo_full),  32'(e_full));
      check(parity_err == m_par,   req, "parity_err", 32'(parity_err), 32'(m_par));
      check(frame_err == m_frm,    req, "frame_err",  32'(frame_err),  32'(m_frm));
      check(overrun_err == m_ovr,  req, "overrun_err", 32'(overrun_err), 32'(m_ovr));
      if (!e_empty) check(rd_data == exp_q[0], req, "rd_data head", rd_data, exp_q[0]);
   endtask

   task automatic drive(input logic v, input int n);
      rx_line = v;
      repeat (n) @(negedge clk);
   endtask

   // Expected parity bit: makes the total count of ones even (R5).
   function automatic logic even_bit(input logic [DW-1:0] d);
      return ^d;
   endfunction

   // Data with a transition at least every four bits, for off-rate senders.
   function automatic logic [DW-1:0] shape(input logic [DW-1:0] r);
      return (r & 32'h6666_6666) | 32'h1111_1111;
   endfunction

   task automatic send_frame(input logic [DW-1:0] d, input int per,
                             input bit bad_par, input logic [1:0] bad_stop);
      logic p;
      p = even_bit(d) ^ bad_par;
      drive(1'b0, per);
      for (int i = 0; i < DW; i++) drive(d[i], per);   // LSB first (R2)
      drive(p, per);
      drive(~bad_stop[0], per);
      drive(~bad_stop[1], per);
      drive(1'b1, 2 * NOM);
      if (bad_stop != 2'b00) begin
         m_frm = 1'b1;                                  // R7
      end else begin
         if (bad_par) m_par = 1'b1;                     // R5
         if (exp_q.size() == DEPTH) m_ovr = 1'b1;       // R9
         else exp_q.push_back(d);
      end
   endtask

   task automatic read_one(input string req);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      if (exp_q.size() != 0) begin
         void'(exp_q.pop_front());
         m_par = 1'b0;                                  // R6
      end
      check_state(req);
   endtask

   task automatic clear_flags(input string req);
      err_clear = 1'b1;
      @(negedge clk);
      err_clear = 1'b0;
      m_par = 1'b0; m_frm = 1'b0; m_ovr = 1'b0;
      check_state(req);
   endtask

   initial begin
      repeat (190_000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL R2 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 reset");

      // R2: single-bit positions and mixed patterns at the nominal rate
      send_frame(32'h0000_0001, NOM, 1'b0, 2'b00); check_state("R2 lsb");
      send_frame(32'h8000_0000, NOM, 1'b0, 2'b00); check_state("R2 msb");
      send_frame(32'hFFFF_FFFF, NOM, 1'b0, 2'b00); check_state("R2 ones");
      send_frame(32'hA5A5_3C3C, NOM, 1'b0, 2'b00); check_state("R2 mixed");
      for (int k = 0; k < 4; k++) read_one("R8 order");
      read_one("R8 read on empty");

      // R3: runt low pulse shorter than half a bit
      drive(1'b0, 6);
      drive(1'b1, 2 * NOM);
      check_state("R3 runt");
      send_frame(32'h1234_5678, NOM, 1'b0, 2'b00); check_state("R3 after runt");
      read_one("R3 drain");

      // R4: slow and fast senders
      send_frame(32'h3333_CCCC, 34, 1'b0, 2'b00); check_state("R4 slow");
      send_frame(32'h3333_CCCC, 30, 1'b0, 2'b00); check_state("R4 fast");
      send_frame(shape(32'hDEAD_BEEF), 34, 1'b0, 2'b00); check_state("R4 slow shaped");
      send_frame(shape(32'h0BAD_F00D), 30, 1'b0, 2'b00); check_state("R4 fast shaped");
      for (int k = 0; k < 4; k++) read_one("R4 drain");

      // R5 / R6: parity error stored, cleared by a read, then by err_clear
      send_frame(32'h0F0F_0001, NOM, 1'b1, 2'b00); check_state("R5 bad parity");
      read_one("R6 read clears parity");
      send_frame(32'h7777_0000, NOM, 1'b1, 2'b00); check_state("R5 bad parity again");
      clear_flags("R6 clear parity");
      read_one("R6 drain");

      // R7: either stop bit low discards the word
      send_frame(32'hCAFE_0001, NOM, 1'b1, 2'b01); check_state("R7 stop1 low");
      send_frame(32'hCAFE_0002, NOM, 1'b0, 2'b10); check_state("R7 stop2 low");
      clear_flags("R10 clear frame");

      // R8 / R9: fill, overrun, drain in order
      for (int k = 0; k < DEPTH + 1; k++) begin
         send_frame(32'h1000_0000 + 32'(k * 32'h0101_0101), NOM, 1'b0, 2'b00);
         check_state(k == DEPTH ? "R9 overrun" : "R8 fill");
      end
      clear_flags("R10 clear overrun");
      for (int k = 0; k < DEPTH; k++) read_one("R8 drain");
      read_one("R8 empty read");

      // Random mix
      for (int n = 0; n < 40; n++) begin
         int sel, per, nrd;
         logic [DW-1:0] d;
         bit bp;
         logic [1:0] bs;
         sel = $urandom_range(0, 2);
         per = (sel == 0) ? 30 : (sel == 1) ? NOM : 34;
         d   = $urandom();
         if (per != NOM) d = shape(d);
         bp  = ($urandom_range(0, 7) == 0);
         bs  = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         send_frame(d, per, bp, bs);
         check_state("R4 random frame");
         nrd = $urandom_range(0, 2);
         for (int k = 0; k < nrd; k++) read_one("R8 random read");
         if ($urandom_range(0, 9) == 0) clear_flags("R10 random clear");
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule